// File: doc/BRIEF.md
# Crosspoint Array Programming Sequencer

This block sits on the host side of a row of daisy-chained crosspoint switch devices that share one serial input. Given a table of output selections for each device in the row, it builds one 30-bit write word per device and shifts the words out one bit per clock, with a clock enable marking each valid bit. After the last bit it waits a fixed gap so the final word can settle in every device's holding stage, and then it pulses a load strobe so all devices apply their new settings together.

For read-back it sends one read frame per device, then keeps the serial input low while the devices return their settings. Each device adds a fixed latency, so the read window is longer than the outgoing data by that latency times the device count. Bits that come back from the last device in the row are collected as 30-bit words. Each word's header is checked, and the device it came from is recovered from the column field, which every device on the way counts down by one. Valid settings are stored in a results table laid out like the input table. A header that does not match sets a sticky error flag.

Top module: `xpArraySeq`

## Requirements
- R1: A write sends NUM_DEV words, most significant bit first, for columns NUM_DEV-1 down to 0 in that order. Each word is {6'b011111, 6-bit row ROW_ADDR, 6-bit column, out0, out1, out2, out3}. out0 sits in bits 11:9 and out3 in bits 2:0. Output o of device d is taken from selTable[(d*NUM_OUT+o)*SEL_W +: SEL_W].
- R2: A write asserts sclkEn for exactly NUM_DEV*30 consecutive cycles (120 with the defaults). The first of these cycles is the one after the start is accepted.
- R3: load is high for exactly one cycle, LOAD_GAP (2) cycles after the last write bit, and never together with sclkEn. done is high for one cycle, in the cycle after load.
- R4: A read asserts sclkEn for NUM_DEV*(30+DEV_LAT) cycles (148 with the defaults). For the first NUM_DEV*30 of these, si carries the word {6'b011110, ROW_ADDR, 6'b111111, 12'b0}, repeated NUM_DEV times. For the rest of the window si is 0.
- R5: During a read, rso is sampled in every sclkEn cycle from cycle index NUM_DEV*DEV_LAT onward, counting from 0. Each group of 30 samples forms one word, first sample as bit 29.
- R6: A returned word whose column field is F belongs to device 63-F. Its bits 11:0 are stored in that device's entry of rdTable, using the same layout as selTable. If a later word names the same device, it overwrites the earlier one.
- R7: A returned word whose bits 29:24 differ from 6'b011110, whose bits 23:18 differ from ROW_ADDR, or whose decoded device is NUM_DEV or more is not stored and sets rdErr. rdErr and rdTable are cleared when a read starts, and rdErr holds until then.
- R8: busy is high from the cycle after an accepted start until done. startWrite and startRead are ignored unless the block is idle. If both arrive together, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial bit per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| startWrite | input | 1 | Start programming the row |
| startRead | input | 1 | Start reading back the row |
| selTable | input | NUM_DEV*NUM_OUT*SEL_W | Per-device output selections |
| sclkEn | output | 1 | Serial clock enable; si and rso are valid in this cycle |
| si | output | 1 | Serial data to the first device |
| load | output | 1 | Apply-configuration strobe |
| rso | input | 1 | Serial data returned by the last device |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdTable | output | NUM_DEV*NUM_OUT*SEL_W | Settings recovered by the last read |
| rdErr | output | 1 | A returned word failed the header or range check |

## Verification
The hardest states to reach are returned words that arrive out of column order, name the same device twice, or carry a bad header or an out-of-range column. Real devices would never produce these. The bench therefore acts as the device row itself: it drives rso with words it builds, delayed by the latency window. It permutes the column order and plants faulty words at chosen positions. It also fires a read request in the middle of a write, and both requests in the same cycle, to show that the sequencer ignores a start while it is not idle.

// File: rtl/xpSeqPkg.sv
package xpSeqPkg;
  localparam int FIELD_W = 6;
  localparam logic [FIELD_W-1:0] WRITE_FRAME = 6'b011111;
  localparam logic [FIELD_W-1:0] READ_FRAME  = 6'b011110;
  localparam logic [FIELD_W-1:0] ADDR_TOP    = 6'h3F;

  typedef struct packed {
    logic               txLoad;    // load a fresh outgoing word
    logic               txIsRead;  // word is a read frame
    logic [FIELD_W-1:0] txDev;     // column of the write word
    logic               shiftOut;  // advance the outgoing shifter
    logic               shiftIn;   // capture rso into the incoming shifter
    logic               capture;   // incoming word is complete this cycle
    logic               clearRes;  // clear results and error
  } seqStrobes_t;
endpackage

// File: rtl/xpSeqControl.sv
module xpSeqControl
  import xpSeqPkg::*;
#(
  parameter int NUM_DEV  = 4,
  parameter int WORD_W   = 30,
  parameter int DEV_LAT  = 7,
  parameter int LOAD_GAP = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startWrite,
  input  logic        startRead,
  output seqStrobes_t strobes,
  output logic        sclkEn,
  output logic        load,
  output logic        busy,
  output logic        done
);
  localparam int SKIP     = NUM_DEV * DEV_LAT;
  localparam int TOTAL_RD = NUM_DEV * WORD_W + SKIP;
  localparam int BIT_W    = $clog2(WORD_W);
  localparam int WCNT_W   = $clog2(NUM_DEV);
  localparam int GAP_W    = $clog2(LOAD_GAP + 1);
  localparam int CYC_W    = $clog2(TOTAL_RD + 1);
  localparam bit HAS_GAP  = (LOAD_GAP >= 2);

  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);
  localparam logic [WCNT_W-1:0] LAST_WORD = WCNT_W'(NUM_DEV - 1);
  localparam logic [GAP_W-1:0]  LAST_GAP  = GAP_W'(LOAD_GAP - 1);
  localparam logic [CYC_W-1:0]  SKIP_C    = CYC_W'(SKIP);
  localparam logic [CYC_W-1:0]  LAST_CYC  = CYC_W'(TOTAL_RD - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WSHIFT, S_WGAP, S_WLOAD, S_RSHIFT, S_FIN
  } state_t;

  state_t            state;
  logic [BIT_W-1:0]  bitCnt;
  logic [WCNT_W-1:0] wordCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic [CYC_W-1:0]  cycCnt;
  logic [BIT_W-1:0]  rxBit;

  logic wordEnd, moreWords, rxActive, rxEnd, rdLast;

  assign wordEnd   = (bitCnt == LAST_BIT);
  assign moreWords = (wordCnt != LAST_WORD);
  assign rxActive  = (cycCnt >= SKIP_C);
  assign rxEnd     = rxActive && (rxBit == LAST_BIT);
  assign rdLast    = (cycCnt == LAST_CYC);

  always_comb begin
    strobes = '0;
    unique case (state)
      S_IDLE: begin
        if (startWrite) begin
          strobes.txLoad = 1'b1;
          strobes.txDev  = FIELD_W'(NUM_DEV - 1);
        end else if (startRead) begin
          strobes.txLoad   = 1'b1;
          strobes.txIsRead = 1'b1;
          strobes.clearRes = 1'b1;
        end
      end
      S_WSHIFT: begin
        strobes.shiftOut = 1'b1;
        if (wordEnd && moreWords) begin
          strobes.txLoad = 1'b1;
          strobes.txDev  = FIELD_W'(NUM_DEV - 2) - FIELD_W'(wordCnt);
        end
      end
      S_RSHIFT: begin
        strobes.shiftOut = 1'b1;
        strobes.shiftIn  = 1'b1;
        strobes.capture  = rxEnd;
        if (wordEnd && moreWords) begin
          strobes.txLoad   = 1'b1;
          strobes.txIsRead = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign sclkEn = (state == S_WSHIFT) || (state == S_RSHIFT);
  assign load   = (state == S_WLOAD);
  assign done   = (state == S_FIN);
  assign busy   = (state != S_IDLE) && (state != S_FIN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      bitCnt  <= '0;
      wordCnt <= '0;
      gapCnt  <= '0;
      cycCnt  <= '0;
      rxBit   <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          bitCnt  <= '0;
          wordCnt <= '0;
          gapCnt  <= '0;
          cycCnt  <= '0;
          rxBit   <= '0;
          if (startWrite)     state <= S_WSHIFT;
          else if (startRead) state <= S_RSHIFT;
        end
        S_WSHIFT: begin
          if (wordEnd) begin
            bitCnt <= '0;
            if (moreWords) begin
              wordCnt <= wordCnt + 1'b1;
            end else begin
              gapCnt <= GAP_W'(1);
              state  <= HAS_GAP ? S_WGAP : S_WLOAD;
            end
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        S_WGAP: begin
          if (gapCnt == LAST_GAP) state <= S_WLOAD;
          else                    gapCnt <= gapCnt + 1'b1;
        end
        S_WLOAD: state <= S_FIN;
        S_RSHIFT: begin
          if (wordEnd) begin
            bitCnt <= '0;
            if (moreWords) wordCnt <= wordCnt + 1'b1;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
          if (rxActive) rxBit <= rxEnd ? '0 : rxBit + 1'b1;
          cycCnt <= cycCnt + 1'b1;
          if (rdLast) state <= S_FIN;
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xpSeqDatapath.sv
module xpSeqDatapath
  import xpSeqPkg::*;
#(
  parameter int NUM_DEV  = 4,
  parameter int NUM_OUT  = 4,
  parameter int SEL_W    = 3,
  parameter int ROW_ADDR = 0
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  seqStrobes_t                      strobes,
  input  logic [NUM_DEV*NUM_OUT*SEL_W-1:0] selTable,
  input  logic                             rso,
  output logic                             si,
  output logic [NUM_DEV*NUM_OUT*SEL_W-1:0] rdTable,
  output logic                             rdErr
);
  localparam int CFG_W  = NUM_OUT * SEL_W;
  localparam int WORD_W = 3 * FIELD_W + CFG_W;
  localparam logic [FIELD_W-1:0] ROW_F = FIELD_W'(ROW_ADDR);

  // outgoing word assembly
  logic [CFG_W-1:0]  txCfg;
  logic [WORD_W-1:0] txWord;
  logic [WORD_W-1:0] txReg;

  always_comb begin
    txCfg = '0;
    if (!strobes.txIsRead) begin
      for (int o = 0; o < NUM_OUT; o++) begin
        txCfg[CFG_W-1-o*SEL_W -: SEL_W] =
          selTable[(int'(strobes.txDev) * NUM_OUT + o) * SEL_W +: SEL_W];
      end
    end
  end

  assign txWord = strobes.txIsRead ? {READ_FRAME, ROW_F, ADDR_TOP, txCfg}
                                   : {WRITE_FRAME, ROW_F, strobes.txDev, txCfg};

  always_ff @(posedge clk) begin
    if (!rstN)                 txReg <= '0;
    else if (strobes.txLoad)   txReg <= txWord;
    else if (strobes.shiftOut) txReg <= {txReg[WORD_W-2:0], 1'b0};
  end

  assign si = txReg[WORD_W-1];

  // incoming word assembly and decode
  logic [WORD_W-2:0]  rxReg;
  logic [WORD_W-1:0]  rxWord;
  logic [FIELD_W-1:0] rxFrame, rxRow, rxCol;
  logic [CFG_W-1:0]   rxCfg;
  logic               rxOk;

  assign rxWord  = {rxReg, rso};
  assign rxFrame = rxWord[WORD_W-1 -: FIELD_W];
  assign rxRow   = rxWord[CFG_W+FIELD_W +: FIELD_W];
  assign rxCol   = ADDR_TOP - rxWord[CFG_W +: FIELD_W];
  assign rxCfg   = rxWord[CFG_W-1:0];
  assign rxOk    = (rxFrame == READ_FRAME) && (rxRow == ROW_F) &&
                   (int'(rxCol) < NUM_DEV);

  always_ff @(posedge clk) begin
    if (!rstN)                rxReg <= '0;
    else if (strobes.shiftIn) rxReg <= rxWord[WORD_W-2:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          rdErr <= 1'b0;
    else if (strobes.clearRes)          rdErr <= 1'b0;
    else if (strobes.capture && !rxOk)  rdErr <= 1'b1;
  end

  // results table, one slot per device
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_slot
    logic [CFG_W-1:0] slotCfg;

    always_ff @(posedge clk) begin
      if (!rstN)                 slotCfg <= '0;
      else if (strobes.clearRes) slotCfg <= '0;
      else if (strobes.capture && rxOk && (rxCol == FIELD_W'(d)))
        slotCfg <= rxCfg;
    end

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      assign rdTable[(d*NUM_OUT+o)*SEL_W +: SEL_W] = slotCfg[CFG_W-1-o*SEL_W -: SEL_W];
    end
  end
endmodule

// File: rtl/xpArraySeq.sv
module xpArraySeq
  import xpSeqPkg::*;
#(
  parameter int NUM_DEV  = 4,
  parameter int NUM_OUT  = 4,
  parameter int SEL_W    = 3,
  parameter int DEV_LAT  = 7,
  parameter int LOAD_GAP = 2,
  parameter int ROW_ADDR = 0
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             startWrite,
  input  logic                             startRead,
  input  logic [NUM_DEV*NUM_OUT*SEL_W-1:0] selTable,
  output logic                             sclkEn,
  output logic                             si,
  output logic                             load,
  input  logic                             rso,
  output logic                             busy,
  output logic                             done,
  output logic [NUM_DEV*NUM_OUT*SEL_W-1:0] rdTable,
  output logic                             rdErr
);
  localparam int WORD_W = 3 * FIELD_W + NUM_OUT * SEL_W;

  seqStrobes_t strobes;

  xpSeqControl #(
    .NUM_DEV (NUM_DEV),
    .WORD_W  (WORD_W),
    .DEV_LAT (DEV_LAT),
    .LOAD_GAP(LOAD_GAP)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .startWrite(startWrite),
    .startRead (startRead),
    .strobes   (strobes),
    .sclkEn    (sclkEn),
    .load      (load),
    .busy      (busy),
    .done      (done)
  );

  xpSeqDatapath #(
    .NUM_DEV (NUM_DEV),
    .NUM_OUT (NUM_OUT),
    .SEL_W   (SEL_W),
    .ROW_ADDR(ROW_ADDR)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .selTable(selTable),
    .rso     (rso),
    .si      (si),
    .rdTable (rdTable),
    .rdErr   (rdErr)
  );
endmodule

// File: rtl/xpArraySeqChecker.sv
module xpArraySeqChecker (
  input logic clk,
  input logic rstN,
  input logic startWrite,
  input logic startRead,
  input logic sclkEn,
  input logic load,
  input logic busy,
  input logic done,
  input logic rdErr
);
  AST_LOAD_SINGLE:     assert property (@(posedge clk) disable iff (!rstN) load |=> !load);                 // R3
  AST_DONE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN) load |=> done);                  // R3
  AST_LOAD_NO_SCLK:    assert property (@(posedge clk) disable iff (!rstN) load |-> (!sclkEn && busy));     // R3
  AST_SCLK_IN_BUSY:    assert property (@(posedge clk) disable iff (!rstN) sclkEn |-> busy);               // R8
  AST_DONE_RELEASE:    assert property (@(posedge clk) disable iff (!rstN) done |=> (!busy && !done));     // R8
  AST_START_BUSY:      assert property (@(posedge clk) disable iff (!rstN)
                         (!busy && !done && (startWrite || startRead)) |=> busy);                            // R8
  AST_ERR_HOLD:        assert property (@(posedge clk) disable iff (!rstN) (rdErr && busy) |=> rdErr);     // R7
  AST_ERR_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
                         (!busy && !startRead) |=> $stable(rdErr));                                          // R7
endmodule

bind xpArraySeq xpArraySeqChecker chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .startWrite(startWrite),
  .startRead (startRead),
  .sclkEn    (sclkEn),
  .load      (load),
  .busy      (busy),
  .done      (done),
  .rdErr     (rdErr)
);

// File: tb/xpArraySeq_tb_top.sv
`timescale 1ns/1ps
module xpArraySeq_tb_top;
  localparam int ND    = 4;
  localparam int NO    = 4;
  localparam int SW    = 3;
  localparam int WW    = 30;
  localparam int TW    = ND * NO * SW;
  localparam int SKIP  = ND * 7;
  localparam int WRTOT = ND * WW;
  localparam int RDTOT = WRTOT + SKIP;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startWrite = 1'b0;
  logic          startRead = 1'b0;
  logic          rso = 1'b0;
  logic [TW-1:0] selTable = '0;
  logic          sclkEn, si, load, busy, done, rdErr;
  logic [TW-1:0] rdTable;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  xpArraySeq dut_i (
    .clk(clk), .rstN(rstN), .startWrite(startWrite), .startRead(startRead),
    .selTable(selTable), .sclkEn(sclkEn), .si(si), .load(load), .rso(rso),
    .busy(busy), .done(done), .rdTable(rdTable), .rdErr(rdErr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [WW-1:0] expWrite(input logic [TW-1:0] tab, input int dev);
    logic [11:0] c;
    for (int o = 0; o < NO; o++) c[11-o*SW -: SW] = tab[(dev*NO+o)*SW +: SW];
    return {6'b011111, 6'd0, 6'(dev), c};
  endfunction

  function automatic logic [11:0] cfgOf(input int seed, input int col);
    logic [11:0] c;
    for (int o = 0; o < NO; o++) c[11-o*SW -: SW] = 3'(((seed + col*NO + o) * 5 + 1) % 8);
    return c;
  endfunction

  function automatic logic [WW-1:0] mkRead(input int col, input logic [11:0] cfg);
    return {6'b011110, 6'd0, 6'(63 - col), cfg};
  endfunction

  // mode 0: plain, 1: read request mid-write, 2: both requests together
  task automatic runWrite(input logic [TW-1:0] tab, input int mode);
    int sclkCnt = 0, bad = 0, lastSclk = -1, loadCyc = -1, loadCnt = 0, doneCyc = -1;
    logic [WW-1:0] w;
    logic [TW-1:0] rdBefore;
    rdBefore = rdTable;
    selTable = tab;
    startWrite = 1'b1;
    startRead = (mode == 2);
    @(negedge clk);
    startWrite = 1'b0;
    startRead = 1'b0;
    for (int cyc = 0; cyc < 600; cyc++) begin
      if (cyc == 0) check(busy == 1'b1, "R8", "busy after write start", busy, 1);
      startRead = (mode == 1 && cyc == 5);
      if (sclkEn) begin
        if (sclkCnt < WRTOT) begin
          w = expWrite(tab, ND - 1 - sclkCnt / WW);
          if (si !== w[WW-1 - sclkCnt % WW]) bad++;
        end
        sclkCnt++;
        lastSclk = cyc;
      end
      if (load) begin loadCnt++; loadCyc = cyc; end
      if (done) begin
        doneCyc = cyc;
        check(busy == 1'b0, "R8", "busy low at done", busy, 0);
        break;
      end
      @(negedge clk);
    end
    startRead = 1'b0;
    check(doneCyc >= 0, "R3", "write completed", doneCyc, 1);
    check(sclkCnt == WRTOT, "R2", "write sclk count", sclkCnt, WRTOT);
    check(lastSclk == WRTOT - 1, "R2", "write bits contiguous", lastSclk, WRTOT - 1);
    check(bad == 0, "R1", "write bit mismatches", bad, 0);
    check(loadCnt == 1, "R3", "load pulse count", loadCnt, 1);
    check(loadCyc - lastSclk == 2, "R3", "load gap", loadCyc - lastSclk, 2);
    check(doneCyc - loadCyc == 1, "R3", "done after load", doneCyc - loadCyc, 1);
    if (mode != 0) begin
      int extra = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (sclkEn || busy) extra++;
      end
      check(extra == 0, "R8", "ignored read start caused activity", extra, 0);
      check(rdTable == rdBefore, "R8", "results untouched by ignored read", rdTable, rdBefore);
    end else begin
      @(negedge clk);
    end
  endtask

  task automatic runRead(input logic [ND-1:0][WW-1:0] words);
    int sclkCnt = 0, bad = 0, doneCyc = -1;
    logic [WW-1:0] rw;
    logic [TW-1:0] expTab;
    logic          expErr;
    logic [5:0]    col;
    rw = {6'b011110, 6'd0, 6'h3F, 12'd0};
    expTab = '0;
    expErr = 1'b0;
    for (int j = 0; j < ND; j++) begin
      col = 6'h3F - words[j][17:12];
      if (words[j][29:24] == 6'b011110 && words[j][23:18] == 6'd0 && int'(col) < ND) begin
        for (int o = 0; o < NO; o++)
          expTab[(int'(col)*NO+o)*SW +: SW] = words[j][11-o*SW -: SW];
      end else begin
        expErr = 1'b1;
      end
    end
    startRead = 1'b1;
    @(negedge clk);
    startRead = 1'b0;
    for (int cyc = 0; cyc < 600; cyc++) begin
      if (cyc == 0) check(busy == 1'b1, "R8", "busy after read start", busy, 1);
      if (sclkEn) begin
        if (sclkCnt < SKIP) rso = 1'b0;
        else rso = words[(sclkCnt - SKIP) / WW][WW-1 - (sclkCnt - SKIP) % WW];
        if (sclkCnt < WRTOT) begin
          if (si !== rw[WW-1 - sclkCnt % WW]) bad++;
        end else if (si !== 1'b0) bad++;
        sclkCnt++;
      end else begin
        rso = 1'b0;
      end
      if (done) begin doneCyc = cyc; break; end
      @(negedge clk);
    end
    rso = 1'b0;
    check(doneCyc >= 0, "R4", "read completed", doneCyc, 1);
    check(sclkCnt == RDTOT, "R4", "read sclk count", sclkCnt, RDTOT);
    check(bad == 0, "R4", "read frame and backfill mismatches", bad, 0);
    check(rdTable == expTab, "R5 R6", "results table", rdTable, expTab);
    check(rdErr == expErr, "R7", "error flag", rdErr, expErr);
    @(negedge clk);
  endtask

  initial begin
    logic [TW-1:0] tab;
    logic [ND-1:0][WW-1:0] words;
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R8", "reset busy/done", {busy, done}, 0);
    check(sclkEn == 1'b0 && load == 1'b0, "R3", "reset sclk/load", {sclkEn, load}, 0);
    check(rdErr == 1'b0 && rdTable == '0, "R7", "reset results", rdErr, 0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(busy == 1'b0 && sclkEn == 1'b0, "R8", "idle after reset", busy, 0);

    // write sweep over several selection tables
    for (int p = 0; p < 8; p++) begin
      for (int d = 0; d < ND; d++)
        for (int o = 0; o < NO; o++)
          tab[(d*NO+o)*SW +: SW] = 3'((p*5 + d*3 + o) % 8);
      runWrite(tab, 0);
    end

    // read sweep over column orders
    for (int r = 0; r < 8; r++) begin
      for (int j = 0; j < ND; j++) begin
        int c;
        c = (r % 2 == 0) ? (j + r / 2) % ND : (ND - 1 - j + r / 2) % ND;
        words[j] = mkRead(c, cfgOf(r, c));
      end
      runRead(words);
    end

    // R8: read request during a write, and both requests at once
    runWrite(~tab, 1);
    runWrite(tab ^ 48'h5A5A5A5A5A5A, 2);

    // R7: bad frame code in one word
    for (int j = 0; j < ND; j++) words[j] = mkRead(ND - 1 - j, cfgOf(11, j));
    words[1][29:24] = 6'b011111;
    runRead(words);
    // R7: out-of-range device and wrong row
    for (int j = 0; j < ND; j++) words[j] = mkRead(j, cfgOf(13, j));
    words[2] = mkRead(ND + 1, cfgOf(14, 2));
    words[0][23:18] = 6'd3;
    runRead(words);
    // R6 R7: good read clears error; duplicate device overwrites, missing slot cleared
    words[0] = mkRead(0, cfgOf(20, 0));
    words[1] = mkRead(0, cfgOf(21, 0));
    words[2] = mkRead(1, cfgOf(22, 1));
    words[3] = mkRead(2, cfgOf(23, 2));
    runRead(words);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule